// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets clocked logic use an external asynchronous static RAM of 256K words by 16 bits. Each access is a single request: a word address, a read or write flag, write data and a two-bit byte mask. The controller turns the request into a timed sequence on the memory pins. These are an active-low chip select, write enable and output enable, active-low strobes for the lower and upper byte lanes, the address bus, and a data bus split into output, input and output-enable. The number of clocks in each phase is computed at elaboration. The nanosecond limits of the memory are divided by the clock period, rounded up, with a floor of one clock.

A request is taken only while the controller is idle and `ready_o` is low. When the access ends, `ready_o` pulses high for one clock. After a read, `rdata_o` holds the captured word. A request whose mask is all zero completes without touching the memory. A write that follows a read gets one extra dead clock, so the controller's drivers never overlap with the memory's drivers.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no request, chip select, write enable, output enable and both lane strobes are high, the data output-enable is low, `ready_o` is low and `rdata_o` is zero.
- R2: A read with a non-zero mask holds CS# and OE# low, WE# high and the data output-enable low, with the request address on the pins, for RD_CYC = ceil(max(tAA, tOE, tBA) / clock period) clocks, at least one.
- R3: On the edge that ends the last read clock, the data bus is captured. In the next clock, `ready_o` is high, every memory pin is idle, and `rdata_o` shows the captured data. Mask bit 0 selects bits 7:0 through the lower strobe and mask bit 1 selects bits 15:8 through the upper strobe. A lane whose mask bit is zero keeps its strobe high and reads back as zero.
- R4: A write first holds CS# and WE# low, OE# high and the data output-enable high, with address and write data on the pins, for WP_CYC = ceil(max(tWP, tDW) / clock period) clocks.
- R5: WE# then returns high while CS# stays low and the address, data and output-enable are held, for WH_CYC = max(1, ceil(tWC / clock period) - WP_CYC) clocks. The clock after that is the ready clock.
- R6: During a write, only the strobes of lanes whose mask bit is set go low, so a lane whose mask bit is clear keeps its old contents in the memory.
- R7: A write whose most recent request with a non-zero mask was a read gets one clock after acceptance with every pin idle before WE# falls. Any other write drives WE# low in the first clock after acceptance.
- R8: A request with an all-zero mask raises `ready_o` in the next clock. It asserts no memory strobe, does not change `rdata_o` and does not change which kind of access counts as the previous one.
- R9: The data output-enable is never high while OE# is low, and it rises only after a clock in which chip select was high.
- R10: A request presented while an access is in progress, or during the ready clock, is ignored. Address and data on the pins do not change during an access.
- R11: `ready_o` is high for exactly one clock per completed request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken when idle and ready is low |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte mask, bit 0 lower lane, bit 1 upper lane |
| ready_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Last read data, disabled lanes zero |
| sram_addr_o | output | 18 | Memory address |
| sram_cs_no | output | 1 | Chip select, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_lb_no | output | 1 | Lower lane strobe, active low |
| sram_ub_no | output | 1 | Upper lane strobe, active low |
| sram_dq_o | output | 16 | Data toward memory |
| sram_dq_oe_o | output | 1 | Enables the data drivers toward memory |
| sram_dq_i | input | 16 | Data from memory |

## Verification
Assertions check the following on every clock:
- WE# is never low without chip select.
- The controller's data drivers never overlap a low OE#.
- The drivers switch on only after a deselected clock.
- Address and data stay steady throughout a selected access.
- The ready pulse lasts one clock.
- An empty request finishes at once with the memory deselected.

Only the bench scenarios can show the rest: the exact phase lengths derived from the timing parameters, the insertion of the turnaround clock, lane gating in the captured read data and in the memory contents, and the rejection of requests held high during busy and ready clocks.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_TURN = 3'd2,
    ST_WP   = 3'd3,
    ST_WH   = 3'd4
  } phase_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // ceil(ns / clk_ns), never below one clock
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R2: a loaded count always counts down by one
  a_r2_timer_counts_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W  = 2,
  parameter int RD_CYC = 1,
  parameter int WP_CYC = 1,
  parameter int WH_CYC = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             be_any_i,
  input  logic             done_i,
  output phase_e           phase_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             ready_o
);

  localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] WH_LD = CNT_W'(WH_CYC - 1);

  phase_e phase_q, phase_d;
  logic   ready_q, ready_d;
  logic   last_rd_q;

  always_comb begin
    phase_d    = phase_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    ready_d    = 1'b0;
    unique case (phase_q)
      ST_IDLE: begin
        if (req_i && !ready_q) begin
          if (!be_any_i) begin
            ready_d = 1'b1;
          end else begin
            accept_o = 1'b1;
            load_o   = 1'b1;
            if (!we_i) begin
              phase_d    = ST_RD;
              load_val_o = RD_LD;
            end else if (last_rd_q) begin
              phase_d    = ST_TURN;
              load_val_o = '0;
            end else begin
              phase_d    = ST_WP;
              load_val_o = WP_LD;
            end
          end
        end
      end
      ST_RD: begin
        if (done_i) begin
          phase_d   = ST_IDLE;
          capture_o = 1'b1;
          ready_d   = 1'b1;
        end
      end
      ST_TURN: begin
        if (done_i) begin
          phase_d    = ST_WP;
          load_o     = 1'b1;
          load_val_o = WP_LD;
        end
      end
      ST_WP: begin
        if (done_i) begin
          phase_d    = ST_WH;
          load_o     = 1'b1;
          load_val_o = WH_LD;
        end
      end
      ST_WH: begin
        if (done_i) begin
          phase_d = ST_IDLE;
          ready_d = 1'b1;
        end
      end
      default: phase_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= ST_IDLE;
      ready_q   <= 1'b0;
      last_rd_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      ready_q <= ready_d;
      if (capture_o)             last_rd_q <= 1'b1;
      else if (phase_q == ST_WP) last_rd_q <= 1'b0;
    end
  end

  assign phase_o = phase_q;
  assign ready_o = ready_q;

  // R11: completion pulse lasts one clock
  a_r11_ready_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  // R8: empty request completes next clock without leaving idle
  a_r8_empty_req_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == ST_IDLE && !ready_q && req_i && !be_any_i) |=> (ready_o && phase_q == ST_IDLE));

  // R10: no new access starts during the ready clock
  a_r10_no_accept_in_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> (phase_q == ST_IDLE));

endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv
  import sram_ctrl_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 16,
  parameter int BW = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          capture_i,
  input  phase_e        phase_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [BW-1:0] be_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_cs_no,
  output logic          mem_we_no,
  output logic          mem_oe_no,
  output logic [BW-1:0] lane_no,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i,
  output logic [DW-1:0] rdata_o
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q, rd_lanes;
  logic [BW-1:0] be_q;
  logic          active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (accept_i) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        be_q    <= be_i;
      end
      if (capture_i) rdata_q <= rd_lanes;
    end
  end

  assign active = (phase_i == ST_RD) || (phase_i == ST_WP) || (phase_i == ST_WH);

  for (genvar g = 0; g < BW; g++) begin : g_lane
    assign lane_no[g]         = !(active && be_q[g]);
    assign rd_lanes[g*8 +: 8] = be_q[g] ? mem_dq_i[g*8 +: 8] : 8'h00;
  end

  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign mem_cs_no   = !active;
  assign mem_oe_no   = (phase_i != ST_RD);
  assign mem_we_no   = (phase_i != ST_WP);
  assign mem_dq_oe_o = (phase_i == ST_WP) || (phase_i == ST_WH);
  assign rdata_o     = rdata_q;

  // R9: controller drivers never fight the memory
  a_r9_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);

  // R9: drivers come on only after a deselected clock
  a_r9_idle_before_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> $past(mem_cs_no));

  // R4: write strobe only inside a selected cycle with data driven
  a_r4_we_with_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_cs_no && mem_oe_no && mem_dq_oe_o));

  // R10: address and data steady across an access
  a_r10_pins_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_no && $past(!mem_cs_no)) |-> ($stable(mem_addr_o) && $stable(mem_dq_o)));

  // R1: deselected means no lane strobe
  a_r1_lanes_off_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_cs_no |-> (&lane_no));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int CLK_NS  = 20,
  parameter int T_AA_NS = 17,
  parameter int T_OE_NS = 7,
  parameter int T_BA_NS = 7,
  parameter int T_WP_NS = 14,
  parameter int T_DW_NS = 10,
  parameter int T_WC_NS = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        be_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_cs_no,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic              sram_lb_no,
  output logic              sram_ub_no,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int RD_CYC  = ns_to_cyc(max2(T_AA_NS, max2(T_OE_NS, T_BA_NS)), CLK_NS);
  localparam int WP_CYC  = ns_to_cyc(max2(T_WP_NS, T_DW_NS), CLK_NS);
  localparam int WC_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int WH_CYC  = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1;
  localparam int MAX_CYC = max2(RD_CYC, max2(WP_CYC, WH_CYC));
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam int BW      = DATA_W / 8;

  phase_e           phase;
  logic             accept, capture, load, done;
  logic [CNT_W-1:0] load_val;
  logic [BW-1:0]    lane_n;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (done)
  );

  sram_seq #(
    .CNT_W  (CNT_W),
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .WH_CYC (WH_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .be_any_i   (|be_i),
    .done_i     (done),
    .phase_o    (phase),
    .accept_o   (accept),
    .capture_o  (capture),
    .load_o     (load),
    .load_val_o (load_val),
    .ready_o    (ready_o)
  );

  sram_pin_drv #(.AW(ADDR_W), .DW(DATA_W), .BW(BW)) u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .capture_i   (capture),
    .phase_i     (phase),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .be_i        (be_i[BW-1:0]),
    .mem_addr_o  (sram_addr_o),
    .mem_cs_no   (sram_cs_no),
    .mem_we_no   (sram_we_no),
    .mem_oe_no   (sram_oe_no),
    .lane_no     (lane_n),
    .mem_dq_o    (sram_dq_o),
    .mem_dq_oe_o (sram_dq_oe_o),
    .mem_dq_i    (sram_dq_i),
    .rdata_o     (rdata_o)
  );

  assign sram_lb_no = lane_n[0];
  assign sram_ub_no = lane_n[BW-1];

endmodule

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;

  localparam int CLK_NS = 20;
  localparam int TAA = 35, TOE = 15, TBA = 15, TWP = 30, TDW = 15, TWC = 70;
  localparam logic [6:0] CTL_IDLE = 7'b1111100;  // cs we oe lb ub dqoe ready
  localparam logic [6:0] CTL_RDY  = 7'b1111101;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic        ready_o, sram_cs_no, sram_we_no, sram_oe_no, sram_lb_no, sram_ub_no, sram_dq_oe_o;
  logic [15:0] rdata_o, sram_dq_o;
  logic [15:0] sram_dq_i = 16'hA55A;
  logic [17:0] sram_addr_o;

  int vectors = 0, fails = 0;
  int e_rd, e_wp, e_wh;
  bit last_rd = 0;
  logic [15:0] rd_model = '0;
  logic [15:0] ref_mem [int];
  logic [15:0] sram_arr [int];

  sram_ctrl #(.CLK_NS(CLK_NS), .T_AA_NS(TAA), .T_OE_NS(TOE), .T_BA_NS(TBA),
              .T_WP_NS(TWP), .T_DW_NS(TDW), .T_WC_NS(TWC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .ready_o(ready_o), .rdata_o(rdata_o),
    .sram_addr_o(sram_addr_o), .sram_cs_no(sram_cs_no), .sram_we_no(sram_we_no),
    .sram_oe_no(sram_oe_no), .sram_lb_no(sram_lb_no), .sram_ub_no(sram_ub_no),
    .sram_dq_o(sram_dq_o), .sram_dq_oe_o(sram_dq_oe_o), .sram_dq_i(sram_dq_i));

  always #10 clk = ~clk;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic logic [15:0] arr_rd(input int a);
    return sram_arr.exists(a) ? sram_arr[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] ref_rd(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
  endfunction

  // behavioural memory: latch on rising WE#, drive read data half a clock later
  always @(posedge sram_we_no) begin
    if (rst_n && !sram_cs_no) begin
      logic [15:0] w;
      w = arr_rd(int'(sram_addr_o));
      if (!sram_lb_no) w[7:0]  = sram_dq_o[7:0];
      if (!sram_ub_no) w[15:8] = sram_dq_o[15:8];
      sram_arr[int'(sram_addr_o)] = w;
    end
  end

  always @(negedge clk) begin
    if (!sram_cs_no && !sram_oe_no && sram_we_no) begin
      logic [15:0] w;
      w = arr_rd(int'(sram_addr_o));
      sram_dq_i <= {sram_ub_no ? 8'hC3 : w[15:8], sram_lb_no ? 8'h3C : w[7:0]};
    end else begin
      sram_dq_i <= 16'hA55A;
    end
  end

  task automatic chk(input string tag, input logic [6:0] e_ctl, input logic [17:0] e_addr,
                     input bit c_addr, input logic [15:0] e_dq, input bit c_dq,
                     input logic [15:0] e_rd_v, input bit c_rd);
    logic [6:0] a_ctl;
    a_ctl = {sram_cs_no, sram_we_no, sram_oe_no, sram_lb_no, sram_ub_no, sram_dq_oe_o, ready_o};
    vectors++;
    if (a_ctl !== e_ctl) begin
      fails++;
      $display("FAIL %s ctl actual=%b expected=%b", tag, a_ctl, e_ctl);
    end else if (c_addr && sram_addr_o !== e_addr) begin
      fails++;
      $display("FAIL %s addr actual=%h expected=%h", tag, sram_addr_o, e_addr);
    end else if (c_dq && sram_dq_o !== e_dq) begin
      fails++;
      $display("FAIL %s dq actual=%h expected=%h", tag, sram_dq_o, e_dq);
    end else if (c_rd && rdata_o !== e_rd_v) begin
      fails++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, rdata_o, e_rd_v);
    end else if (sram_dq_oe_o && !sram_oe_no) begin
      fails++;
      $display("FAIL R9 contention actual=oe_low expected=oe_high");
    end
  endtask

  // while busy, optionally keep a conflicting request on the inputs (R10)
  task automatic busy_drive(input bit hold, input bit w, input logic [17:0] a, input logic [15:0] d);
    req = hold;
    if (hold) begin
      we = ~w; addr = ~a; wdata = ~d; be = 2'b11;
    end
  endtask

  task automatic op(input bit w, input logic [17:0] a, input logic [15:0] d,
                    input logic [1:0] m, input bit hold);
    logic [15:0] lm, exp_v, nw;
    lm = {{8{m[1]}}, {8{m[0]}}};
    req = 1'b1; we = w; addr = a; wdata = d; be = m;
    if (m == 2'b00) begin
      @(negedge clk); busy_drive(hold, w, a, d);
      chk("R8", CTL_RDY, a, 0, d, 0, rd_model, 1);
    end else if (!w) begin
      exp_v = ref_rd(int'(a)) & lm;
      for (int i = 0; i < e_rd; i++) begin
        @(negedge clk); busy_drive(hold, w, a, d);
        chk(hold ? "R10" : "R2", {1'b0, 1'b1, 1'b0, ~m[0], ~m[1], 1'b0, 1'b0}, a, 1, 16'h0, 0, 16'h0, 0);
      end
      @(negedge clk); busy_drive(hold, w, a, d);
      rd_model = exp_v;
      chk("R3", CTL_RDY, a, 0, d, 0, exp_v, 1);
      last_rd = 1;
    end else begin
      if (last_rd) begin
        @(negedge clk); busy_drive(hold, w, a, d);
        chk("R7", CTL_IDLE, a, 0, d, 0, rd_model, 0);
      end
      for (int i = 0; i < e_wp; i++) begin
        @(negedge clk); busy_drive(hold, w, a, d);
        chk((m == 2'b11) ? "R4" : "R6", {1'b0, 1'b0, 1'b1, ~m[0], ~m[1], 1'b1, 1'b0}, a, 1, d, 1, 16'h0, 0);
      end
      for (int i = 0; i < e_wh; i++) begin
        @(negedge clk); busy_drive(hold, w, a, d);
        chk("R5", {1'b0, 1'b1, 1'b1, ~m[0], ~m[1], 1'b1, 1'b0}, a, 1, d, 1, 16'h0, 0);
      end
      @(negedge clk); busy_drive(hold, w, a, d);
      chk("R5", CTL_RDY, a, 0, d, 0, rd_model, 1);
      nw = (ref_rd(int'(a)) & ~lm) | (d & lm);
      ref_mem[int'(a)] = nw;
      last_rd = 0;
    end
    @(negedge clk); req = 1'b0;
    chk("R11", CTL_IDLE, a, 0, d, 0, rd_model, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    e_rd = cyc((TAA > TOE) ? ((TAA > TBA) ? TAA : TBA) : ((TOE > TBA) ? TOE : TBA));
    e_wp = cyc((TWP > TDW) ? TWP : TDW);
    e_wh = (cyc(TWC) > e_wp) ? cyc(TWC) - e_wp : 1;

    repeat (2) @(negedge clk);
    chk("R1", CTL_IDLE, '0, 0, '0, 0, 16'h0000, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", CTL_IDLE, '0, 0, '0, 0, 16'h0000, 1);
    @(negedge clk);
    chk("R1", CTL_IDLE, '0, 0, '0, 0, 16'h0000, 1);

    op(1, 18'h00010, 16'h1234, 2'b11, 0);   // R4 full write, no turnaround
    op(0, 18'h00010, 16'h0000, 2'b11, 0);   // R2 R3 read back
    op(1, 18'h3FFFF, 16'hBEEF, 2'b11, 0);   // R7 write after read, top address
    op(1, 18'h00010, 16'hAB77, 2'b01, 0);   // R6 lower lane only
    op(1, 18'h3FFFF, 16'h5500, 2'b10, 0);   // R6 upper lane only
    op(0, 18'h00010, 16'h0000, 2'b11, 0);   // R6 upper lane kept: 1277
    op(0, 18'h3FFFF, 16'h0000, 2'b10, 1);   // R3 lower lane zero, R10 held req
    op(0, 18'h00020, 16'h0000, 2'b00, 0);   // R8 empty read keeps rdata
    op(1, 18'h00020, 16'hDEAD, 2'b00, 0);   // R8 empty write, no memory access
    op(1, 18'h00000, 16'hFFFF, 2'b11, 0);   // R7 turnaround still owed after empty requests
    op(1, 18'h00001, 16'h0F0F, 2'b11, 1);   // R7 no turnaround, R10 held req
    op(0, 18'h00000, 16'h0000, 2'b01, 0);   // R3 lower lane only
    op(0, 18'h00020, 16'h0000, 2'b11, 0);   // R8 empty write left location untouched
    op(0, 18'h00001, 16'h0000, 2'b11, 1);   // R10 read with held req

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule